// File: doc/BRIEF.md
# Floating-Point Exception Trap Unit

This unit sits beside a floating-point datapath and decides, one request per cycle, whether the outcome of an operation must trap. It handles two kinds of request. A flag request carries the exception flags that one operation raised, together with an ignore mask, a software-completion mode bit and the number of the destination register. An operand-screening request carries a raw 64-bit double-precision source value that is classified before the operation uses it. Both kinds of request accumulate into a sticky status register. The flag policy with software completion also consults an enable register.

The trap decision, the trap summary word and the one-hot destination mask are combinational and appear in the same cycle as the request. The status register is updated at the next rising clock edge. Software loads the status and enable registers through one write port, and these registers are the only way to clear status bits.

The six exception kinds use fixed bit positions in the status register, the enable register and the low six bits of the summary: invalid = bit 0, divide-by-zero = bit 1, overflow = bit 2, underflow = bit 3, inexact = bit 4, integer overflow = bit 5. Summary bit 6 is the software-completion marker. The request kind encoding is 0 = flags, 1 = plain screen, 2 = compare screen, 3 = software-completion screen.

Top module: `fp_trap_unit`

## Requirements
- R1: When the synchronous active-low reset is asserted, status and enable become zero. With `valid_i` low, `trap_o` is low, the summary is zero and the destination mask is zero.
- R2: While `valid_i` is low, no trap is raised and status does not change, whatever the other request inputs hold.
- R3: In a flag request with `swc_i`=0, every raised flag is ORed into status, including ignored flags. A trap fires if and only if `exc_flags_i & ~ignore_i` is nonzero. The summary is exactly those remaining flags, with the marker bit 6 clear. The enable register has no effect.
- R4: In a flag request with `swc_i`=1, only `exc_flags_i & ~ignore_i` is ORed into status. A trap fires if and only if that value is nonzero. The summary is that value ANDed with enable, with marker bit 6 set. If enable masks every raised flag, the summary holds only the marker.
- R5: On a flag-request trap, `trap_dest_o` has exactly bit `dest_reg_i` set. Without a trap it is zero.
- R6: Plain screen (kind 1): the exponent is operand bits 62:52 and the fraction is bits 51:0. A zero exponent with a nonzero fraction traps with summary = invalid only, and status is untouched. An all-ones exponent traps with summary = invalid and also sets the invalid status bit. Zeros and normal values pass.
- R7: Compare screen (kind 2): infinities pass. NaNs trap as invalid and set the invalid status bit. Denormals trap as invalid without touching status.
- R8: Software-completion screen (kind 3): a denormal of either sign traps with summary = invalid plus marker (0x41), unless `ftz_i` is high. Zeros, normals, infinities and NaNs pass, and status is untouched.
- R9: When `cfg_we_i` is high, status and enable are loaded from the write data at the next edge. The write wins over any accumulation in the same cycle.
- R10: Status bits are sticky: without a write they never return from 1 to 0.
- R11: Screening requests ignore `exc_flags_i`, `ignore_i`, `swc_i` and the enable register. Their traps report a zero destination mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Request present this cycle |
| req_kind_i | input | 2 | 0 flags, 1 plain screen, 2 compare screen, 3 software-completion screen |
| swc_i | input | 1 | Software-completion policy for flag requests |
| exc_flags_i | input | 6 | Flags raised by the operation |
| ignore_i | input | 6 | Flags to be ignored |
| dest_reg_i | input | 6 | Destination register number |
| operand_i | input | 64 | Raw double-precision operand for screening |
| ftz_i | input | 1 | Inputs are flushed to zero |
| cfg_we_i | input | 1 | Load status and enable |
| cfg_status_i | input | 6 | Status write data |
| cfg_enable_i | input | 6 | Enable write data |
| trap_o | output | 1 | Trap strobe, same cycle as the request |
| trap_summary_o | output | 7 | Exception bits 5:0 and software-completion marker bit 6 |
| trap_dest_o | output | 64 | One-hot destination register mask |
| status_o | output | 6 | Sticky status register |
| enable_o | output | 6 | Enable register |

## Verification
The trap strobe, summary and destination mask depend on the current inputs and the registered enable value, so they are due in the cycle the request is presented. The effect of a request or a write on status and enable becomes visible one rising edge later. The bench applies each request at a falling edge and compares every output 1 ns later against its behavioural model. It advances the modelled registers only at the rising edge, so each comparison sees the same-cycle decision and the registers left by the previous cycle.

// File: rtl/fp_trap_pkg.sv
// Package: shared widths, exception bit positions and request kinds
// for the floating-point exception trap unit.
package fp_trap_pkg;
    localparam int EXC_W   = 6;
    localparam int SUM_W   = EXC_W + 1;
    localparam int SWC_BIT = EXC_W;

    localparam int EXC_INV = 0;
    localparam int EXC_DZE = 1;
    localparam int EXC_OVF = 2;
    localparam int EXC_UNF = 3;
    localparam int EXC_INE = 4;
    localparam int EXC_IOV = 5;

    typedef enum logic [1:0] {
        REQ_FLAGS     = 2'd0,
        REQ_SCR_PLAIN = 2'd1,
        REQ_SCR_CMP   = 2'd2,
        REQ_SCR_SWC   = 2'd3
    } req_kind_e;
endpackage

// File: rtl/fp_trap_csr.sv
// Module: fp_trap_csr
// Holds the sticky status register and the enable register.
// Assumes: acc_i is already gated by request validity; a software write
// has priority over accumulation in the same cycle.
module fp_trap_csr
    import fp_trap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [EXC_W-1:0] wr_status_i,
    input  logic [EXC_W-1:0] wr_enable_i,
    input  logic [EXC_W-1:0] acc_i,
    output logic [EXC_W-1:0] status_o,
    output logic [EXC_W-1:0] enable_o
);
    logic [EXC_W-1:0] status_q;
    logic [EXC_W-1:0] enable_q;

    // Status: reset, load on write, otherwise collect sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= '0;
        else if (wr_en_i) status_q <= wr_status_i;
        else              status_q <= status_q | acc_i;
    end

    // Enable: reset, load on write only.
    always_ff @(posedge clk) begin
        if (!rst_n)       enable_q <= '0;
        else if (wr_en_i) enable_q <= wr_enable_i;
    end

    assign status_o = status_q;
    assign enable_o = enable_q;

    assert_sticky_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((status_q & $past(status_q)) == $past(status_q)));

    assert_write_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (status_q == $past(wr_status_i)) && (enable_q == $past(wr_enable_i)));
endmodule

// File: rtl/fp_flag_policy.sv
// Module: fp_flag_policy
// Applies one of two trap policies to the flags raised by one operation.
// Assumes: purely combinational; the caller gates validity.
module fp_flag_policy
    import fp_trap_pkg::*;
(
    input  logic             swc_i,
    input  logic [EXC_W-1:0] flags_i,
    input  logic [EXC_W-1:0] ignore_i,
    input  logic [EXC_W-1:0] enable_i,
    output logic             raise_o,
    output logic [SUM_W-1:0] summary_o,
    output logic [EXC_W-1:0] acc_o
);
    logic [EXC_W-1:0] live;

    // Decide trap, summary and status contribution for the selected policy.
    always_comb begin
        live    = flags_i & ~ignore_i;
        raise_o = |live;
        if (swc_i) begin
            acc_o     = live;
            summary_o = {1'b1, live & enable_i};
        end else begin
            acc_o     = flags_i;
            summary_o = {1'b0, live};
        end
    end
endmodule

// File: rtl/fp_opnd_screen.sv
// Module: fp_opnd_screen
// Classifies a raw double-precision operand and flags forbidden classes
// for the selected screening mode.
// Assumes: combinational; kind REQ_FLAGS yields no hit.
module fp_opnd_screen
    import fp_trap_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int DATA_W = EXP_W + FRAC_W + 1
) (
    input  logic [DATA_W-1:0] operand_i,
    input  req_kind_e         kind_i,
    input  logic              ftz_i,
    output logic              hit_o,
    output logic [SUM_W-1:0]  summary_o,
    output logic [EXC_W-1:0]  acc_o
);
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic exp_zero, exp_ones, frac_nz, denorm, nan_val, tiny_any_sign;

    // Split the operand into fields and derive its class.
    always_comb begin
        sign          = operand_i[DATA_W-1];
        expo          = operand_i[DATA_W-2 -: EXP_W];
        frac          = operand_i[FRAC_W-1:0];
        exp_zero      = (expo == '0);
        exp_ones      = (expo == '1);
        frac_nz       = (frac != '0);
        denorm        = exp_zero && frac_nz;
        nan_val       = exp_ones && frac_nz;
        tiny_any_sign = (denorm && sign) || (denorm && !sign);
    end

    // Apply the rules of the selected screening mode.
    always_comb begin
        hit_o     = 1'b0;
        summary_o = '0;
        acc_o     = '0;
        summary_o[EXC_INV] = 1'b1;
        unique case (kind_i)
            REQ_SCR_PLAIN: begin
                hit_o = denorm || exp_ones;
                acc_o[EXC_INV] = exp_ones;
            end
            REQ_SCR_CMP: begin
                hit_o = denorm || nan_val;
                acc_o[EXC_INV] = nan_val;
            end
            REQ_SCR_SWC: begin
                hit_o = tiny_any_sign && !ftz_i;
                summary_o[SWC_BIT] = 1'b1;
            end
            default: begin
                hit_o     = 1'b0;
                summary_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/fp_dest_decode.sv
// Module: fp_dest_decode
// Turns a register index into a one-hot register mask when enabled.
// Assumes: REG_CNT is at most 2**IDX_W.
module fp_dest_decode #(
    parameter int REG_CNT = 64,
    localparam int IDX_W  = $clog2(REG_CNT)
) (
    input  logic               en_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [REG_CNT-1:0] mask_o
);
    for (genvar g = 0; g < REG_CNT; g++) begin : g_bit
        // One comparator per register bit.
        assign mask_o[g] = en_i && (idx_i == IDX_W'(g));
    end
endmodule

// File: rtl/fp_trap_unit.sv
// Module: fp_trap_unit (top)
// Decides per cycle whether a floating-point request traps, builds the
// trap summary and destination mask, and maintains status/enable.
// Assumes: one request per cycle; trap outputs are combinational and
// valid in the request cycle; register effects appear after the edge.
module fp_trap_unit
    import fp_trap_pkg::*;
#(
    parameter int REG_CNT = 64,
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    localparam int IDX_W  = $clog2(REG_CNT),
    localparam int DATA_W = EXP_W + FRAC_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [1:0]         req_kind_i,
    input  logic               swc_i,
    input  logic [EXC_W-1:0]   exc_flags_i,
    input  logic [EXC_W-1:0]   ignore_i,
    input  logic [IDX_W-1:0]   dest_reg_i,
    input  logic [DATA_W-1:0]  operand_i,
    input  logic               ftz_i,
    input  logic               cfg_we_i,
    input  logic [EXC_W-1:0]   cfg_status_i,
    input  logic [EXC_W-1:0]   cfg_enable_i,
    output logic               trap_o,
    output logic [SUM_W-1:0]   trap_summary_o,
    output logic [REG_CNT-1:0] trap_dest_o,
    output logic [EXC_W-1:0]   status_o,
    output logic [EXC_W-1:0]   enable_o
);
    req_kind_e        kind;
    logic             is_flags;
    logic             pol_raise, scr_hit, flag_trap;
    logic [SUM_W-1:0] pol_sum, scr_sum;
    logic [EXC_W-1:0] pol_acc, scr_acc, acc;

    assign kind     = req_kind_e'(req_kind_i);
    assign is_flags = (kind == REQ_FLAGS);

    fp_flag_policy u_policy (
        .swc_i     (swc_i),
        .flags_i   (exc_flags_i),
        .ignore_i  (ignore_i),
        .enable_i  (enable_o),
        .raise_o   (pol_raise),
        .summary_o (pol_sum),
        .acc_o     (pol_acc)
    );

    fp_opnd_screen #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_screen (
        .operand_i (operand_i),
        .kind_i    (kind),
        .ftz_i     (ftz_i),
        .hit_o     (scr_hit),
        .summary_o (scr_sum),
        .acc_o     (scr_acc)
    );

    // Select the active path and gate everything by request validity.
    always_comb begin
        trap_o         = valid_i && (is_flags ? pol_raise : scr_hit);
        trap_summary_o = trap_o ? (is_flags ? pol_sum : scr_sum) : '0;
        acc            = valid_i ? (is_flags ? pol_acc : scr_acc) : '0;
        flag_trap      = trap_o && is_flags;
    end

    fp_dest_decode #(.REG_CNT(REG_CNT)) u_dest (
        .en_i   (flag_trap),
        .idx_i  (dest_reg_i),
        .mask_o (trap_dest_o)
    );

    fp_trap_csr u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (cfg_we_i),
        .wr_status_i (cfg_status_i),
        .wr_enable_i (cfg_enable_i),
        .acc_i       (acc),
        .status_o    (status_o),
        .enable_o    (enable_o)
    );

    assert_no_trap_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> !trap_o && (trap_summary_o == '0));

    assert_swc_marker_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && is_flags && swc_i) |-> trap_summary_o[SWC_BIT]);

    assert_plain_no_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && is_flags && !swc_i) |-> !trap_summary_o[SWC_BIT]);

    assert_dest_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trap_dest_o) && ((trap_dest_o != '0) == (trap_o && is_flags)));

    assert_screen_no_dest_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && !is_flags) |-> (trap_dest_o == '0));

    assert_cmp_inf_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind == REQ_SCR_CMP && operand_i[DATA_W-2 -: EXP_W] == '1
         && operand_i[FRAC_W-1:0] == '0) |-> !trap_o);

    assert_ftz_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && kind == REQ_SCR_SWC && ftz_i) |-> !trap_o);
endmodule

// File: tb/fp_trap_unit_tb_top.sv
module fp_trap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [1:0]  req_kind_i = 2'd0;
    logic        swc_i = 1'b0;
    logic [5:0]  exc_flags_i = '0, ignore_i = '0, dest_reg_i = '0;
    logic [63:0] operand_i = '0;
    logic        ftz_i = 1'b0, cfg_we_i = 1'b0;
    logic [5:0]  cfg_status_i = '0, cfg_enable_i = '0;
    logic        trap_o;
    logic [6:0]  trap_summary_o;
    logic [63:0] trap_dest_o;
    logic [5:0]  status_o, enable_o;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [5:0] m_status = '0, m_enable = '0;

    localparam logic [63:0] POS_DEN = 64'h0000_0000_0000_0001;
    localparam logic [63:0] NEG_DEN = 64'h800F_FFFF_FFFF_FFFF;
    localparam logic [63:0] POS_INF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] NEG_INF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QNAN    = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] ONE     = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] NEG_Z   = 64'h8000_0000_0000_0000;

    always #5 clk = ~clk;

    fp_trap_unit dut_i (.*);

    // Behavioural expectation for the current inputs and modelled registers.
    task automatic expect_now(output logic e_trap, output logic [6:0] e_sum,
                              output logic [63:0] e_dest, output logic [5:0] e_acc);
        int ex = int'(operand_i[62:52]);
        bit fz = (operand_i[51:0] == 0);
        e_trap = 0; e_sum = 0; e_dest = 0; e_acc = 0;
        if (valid_i) begin
            if (req_kind_i == 0) begin
                logic [5:0] rem = exc_flags_i & ~ignore_i;
                e_trap = (rem != 0);
                if (swc_i) begin
                    e_acc = rem;
                    if (e_trap) e_sum = 7'h40 | {1'b0, rem & m_enable};
                end else begin
                    e_acc = exc_flags_i;
                    if (e_trap) e_sum = {1'b0, rem};
                end
                if (e_trap) e_dest = 64'd1 << dest_reg_i;
            end else begin
                bit den = (ex == 0) && !fz;
                bit top = (ex == 2047);
                if (req_kind_i == 1) begin
                    e_trap = den || top;
                    if (top) e_acc = 6'h01;
                    if (e_trap) e_sum = 7'h01;
                end else if (req_kind_i == 2) begin
                    e_trap = den || (top && !fz);
                    if (top && !fz) e_acc = 6'h01;
                    if (e_trap) e_sum = 7'h01;
                end else begin
                    e_trap = den && !ftz_i;
                    if (e_trap) e_sum = 7'h41;
                end
            end
        end
    endtask

    // Compare all outputs mid-cycle, then advance the model at the rising edge.
    task automatic step(string tag);
        logic       e_trap;
        logic [6:0] e_sum;
        logic [63:0] e_dest;
        logic [5:0] e_acc;
        #1;
        expect_now(e_trap, e_sum, e_dest, e_acc);
        checks++;
        if (trap_o !== e_trap || trap_summary_o !== e_sum || trap_dest_o !== e_dest ||
            status_o !== m_status || enable_o !== m_enable) begin
            fails++;
            $display("FAIL %s: got trap=%0b sum=%h dest=%h st=%h en=%h exp trap=%0b sum=%h dest=%h st=%h en=%h",
                     tag, trap_o, trap_summary_o, trap_dest_o, status_o, enable_o,
                     e_trap, e_sum, e_dest, m_status, m_enable);
        end
        @(posedge clk);
        if (!rst_n) begin m_status = 0; m_enable = 0; end
        else if (cfg_we_i) begin m_status = cfg_status_i; m_enable = cfg_enable_i; end
        else m_status = m_status | e_acc;
        @(negedge clk);
    endtask

    task automatic flags(bit s, logic [5:0] f, logic [5:0] ig, logic [5:0] d, string tag);
        valid_i = 1; req_kind_i = 0; swc_i = s; exc_flags_i = f; ignore_i = ig; dest_reg_i = d;
        step(tag);
        valid_i = 0;
    endtask

    task automatic screen(logic [1:0] k, logic [63:0] v, bit fz, string tag);
        valid_i = 1; req_kind_i = k; operand_i = v; ftz_i = fz;
        exc_flags_i = 6'h3F; ignore_i = 0; swc_i = 1;
        step(tag);
        valid_i = 0; exc_flags_i = 0; ftz_i = 0;
    endtask

    task automatic write(logic [5:0] s, logic [5:0] e, string tag);
        cfg_we_i = 1; cfg_status_i = s; cfg_enable_i = e;
        step(tag);
        cfg_we_i = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1;
        step("R1");                                   // reset state
        // R2: flags presented with valid low
        req_kind_i = 0; exc_flags_i = 6'h3F; swc_i = 0; step("R2");
        req_kind_i = 1; operand_i = QNAN; step("R2"); exc_flags_i = 0;
        // R3: policy without software completion
        flags(0, 6'h11, 6'h10, 6'd7, "R3");
        flags(0, 6'h10, 6'h10, 6'd7, "R3");
        step("R10");
        write(6'h00, 6'h06, "R9");
        flags(0, 6'h28, 6'h00, 6'd3, "R3");
        write(6'h00, 6'h06, "R9");
        // R4: policy with software completion
        flags(1, 6'h14, 6'h10, 6'd9, "R4");
        flags(1, 6'h10, 6'h00, 6'd9, "R4");
        flags(1, 6'h10, 6'h10, 6'd9, "R4");
        flags(1, 6'h06, 6'h00, 6'd12, "R4");
        // R5: destination extremes
        flags(0, 6'h02, 6'h00, 6'd0, "R5");
        flags(0, 6'h02, 6'h00, 6'd63, "R5");
        write(6'h00, 6'h3F, "R9");
        // R6: plain screening
        screen(1, POS_DEN, 0, "R6"); screen(1, ONE, 0, "R6");
        screen(1, NEG_Z, 0, "R6");   screen(1, POS_INF, 0, "R6");
        write(6'h00, 6'h3F, "R9");
        screen(1, QNAN, 0, "R6");
        write(6'h00, 6'h3F, "R9");
        // R7: compare screening
        screen(2, NEG_INF, 0, "R7"); screen(2, POS_INF, 0, "R7");
        screen(2, NEG_DEN, 0, "R7"); screen(2, QNAN, 0, "R7");
        write(6'h00, 6'h3F, "R9");
        // R8: software-completion screening
        screen(3, POS_DEN, 0, "R8"); screen(3, NEG_DEN, 0, "R8");
        screen(3, POS_DEN, 1, "R8"); screen(3, QNAN, 0, "R8");
        screen(3, POS_INF, 0, "R8"); screen(3, NEG_Z, 0, "R8");
        // R11: screen ignores flag inputs and enable; dest zero
        dest_reg_i = 6'd5; screen(1, NEG_DEN, 0, "R11"); step("R11");
        // R9: write beats same-cycle accumulation
        valid_i = 1; req_kind_i = 0; swc_i = 0; exc_flags_i = 6'h3F; ignore_i = 0;
        cfg_we_i = 1; cfg_status_i = 6'h02; cfg_enable_i = 6'h21;
        step("R9");
        valid_i = 0; cfg_we_i = 0; step("R9");
        // R10: sticky over idle cycles
        flags(0, 6'h20, 6'h00, 6'd1, "R10");
        repeat (5) step("R10");
        // R1: reset mid-run clears registers
        rst_n = 0; step("R1"); rst_n = 1; step("R1");
        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            int c = $urandom_range(0, 5);
            valid_i = ($urandom_range(0, 3) != 0);
            req_kind_i = 2'($urandom_range(0, 3));
            swc_i = 1'($urandom); ftz_i = 1'($urandom_range(0, 3) == 0);
            exc_flags_i = 6'($urandom); ignore_i = 6'($urandom); dest_reg_i = 6'($urandom);
            cfg_we_i = ($urandom_range(0, 15) == 0);
            cfg_status_i = 6'($urandom); cfg_enable_i = 6'($urandom);
            case (c)
                0: operand_i = {1'($urandom), 11'd0, 52'($urandom)};
                1: operand_i = {1'($urandom), 11'h7FF, 52'd0};
                2: operand_i = {1'($urandom), 11'h7FF, 52'($urandom) | 52'd1};
                3: operand_i = {1'($urandom), 63'd0};
                default: operand_i = {$urandom, $urandom};
            endcase
            step(req_kind_i == 0 ? (swc_i ? "R4" : "R3") : "R11");
        end
        valid_i = 0; cfg_we_i = 0; step("R2");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule